// File: doc/BRIEF.md
# Memory-Mapped Serial Port Controller

This block is a byte-wide asynchronous serial port that software drives through a small 32-bit register bus. A write to the data offset queues one byte for transmission. Bytes that arrive on the receive line are collected and read back through the same offset. Each direction has its own 16-entry queue. Each direction also has an enable bit and a flush bit in the control word. A status word reports three things: whether the receive queue is empty, whether the transmit queue is full, and whether the transmitter still has work.

Bit timing comes from an external sample strobe. `OVS` strobes make one bit period. The frame is always one start bit, eight data bits and one stop bit, with no parity. Software is expected to poll the full flag before each write and the empty flag before each read.

A bus read returns its data on the edge after the one on which `bus_rd` was sampled. Writes take effect on the edge that samples them.

Top module: `ser_port_ctrl`

## Requirements
- R1: After reset every register reads zero except status, which reads 0x002 (receive queue empty), and `txd` is high.
- R2: Control sits at offset 0x00. Bit 4 enables the transmitter and bit 2 enables the receiver; both hold their value and read back at those positions. All other bits read as zero.
- R3: Offset 0x04 holds an 11-bit mode word, bits [10:0], which reads back as written; the upper bits read zero. The frame format is 8N1 whatever the mode word holds.
- R4: Status sits at offset 0x2C. Bit 1 is set while the receive queue is empty, bit 4 while the transmit queue holds 16 bytes, and bit 11 while the transmitter is active. All other bits are zero.
- R5: The transmit line idles high. Each frame is a low start bit, then the eight data bits LSB first, then a high stop bit. Every bit lasts `OVS` sample strobes.
- R6: A write to offset 0x30 queues its low byte for transmission. A write made while 16 bytes are already queued is dropped.
- R7: A new frame starts only while the transmit enable bit is set. Queued bytes wait while it is clear.
- R8: Transmitter-active is high while the transmit queue is non-empty or a frame is on the line.
- R9: The receiver samples each bit in the middle of its period and queues the byte it received. A read at 0x30 pops the oldest byte. A read made while the receive queue is empty returns 0.
- R10: A frame whose stop bit samples low is discarded, and nothing is queued for it.
- R11: Writing bit 1 of control flushes the transmit queue and aborts any frame in progress, leaving the line high. Writing bit 0 flushes the receive queue and the receiver. Both bits act once, may share a write with the enable bits, and always read as zero.
- R12: Offsets other than 0x00, 0x04, 0x2C and 0x30 read zero, and writes to them change nothing.
- R13: While the receive enable bit is clear, frames on `rxd` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_tick | input | 1 | Sample strobe; `OVS` strobes make one bit period |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; pops the receive queue at offset 0x30 |
| bus_rdata | output | 32 | Read data, registered |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line (asynchronous) |

## Verification
The bench targets the full-queue edge. A seventeenth queued byte must vanish, so a design that wrapped its write pointer would transmit a corrupted sequence, and one that blocked early would lose the sixteenth byte. Frames carrying 0x00 and 0xFF catch a bit-order or stop-bit error on the line. A receiver that ignored the stop sample would queue a byte from a frame whose stop bit is low. A receiver that resynchronised on that low stop bit would queue a phantom byte. Flushes are issued together with enable bits and in the middle of a frame. A design that latched the flush bits would keep clearing its queues, and one that kept the shifter running would leave the line low or send stale data.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_MODE = 8'h04;
  localparam logic [7:0] OFS_STAT = 8'h2C;
  localparam logic [7:0] OFS_DATA = 8'h30;

  localparam int CB_TX_EN  = 4;
  localparam int CB_RX_EN  = 2;
  localparam int CB_TX_CLR = 1;
  localparam int CB_RX_CLR = 0;

  localparam int SB_RX_EMPTY = 1;
  localparam int SB_TX_FULL  = 4;
  localparam int SB_TX_ACT   = 11;

  localparam int MODE_W = 11;

  typedef enum logic {TX_IDLE, TX_SEND} tx_state_t;
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_HOLD} rx_state_t;
endpackage

// File: rtl/ser_fifo.sv
module ser_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   FULLC = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == FULLC);
  assign empty   = (cnt == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULLC);
  assert_full_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !clr) |=> cnt == $past(cnt));
endmodule

// File: rtl/ser_tx.sv
module ser_tx
  import ser_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       tick,
  input  logic       en,
  input  logic       q_empty,
  input  logic [7:0] q_data,
  output logic       q_pop,
  output logic       txd,
  output logic       busy
);
  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] CLAST = CW'(OVS - 1);

  tx_state_t     st;
  logic [CW-1:0] cnt;
  logic [3:0]    bitn;
  logic [9:0]    sh;

  assign q_pop = (st == TX_IDLE) && en && !q_empty && !clr;
  assign busy  = (st == TX_SEND);
  assign txd   = sh[0];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st   <= TX_IDLE;
      sh   <= '1;
      cnt  <= '0;
      bitn <= '0;
    end else begin
      case (st)
        TX_IDLE: if (q_pop) begin
          sh   <= {1'b1, q_data, 1'b0};
          st   <= TX_SEND;
          cnt  <= '0;
          bitn <= '0;
        end
        TX_SEND: if (tick) begin
          if (cnt == CLAST) begin
            cnt <= '0;
            sh  <= {1'b1, sh[9:1]};
            if (bitn == 4'd9) st <= TX_IDLE;
            else              bitn <= bitn + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  assert_idle_high_R5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
  assert_start_low_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !txd);
endmodule

// File: rtl/ser_rx.sv
module ser_rx
  import ser_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       tick,
  input  logic       en,
  input  logic       rxd,
  output logic       push,
  output logic [7:0] data
);
  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] CLAST = CW'(OVS - 1);
  localparam logic [CW-1:0] CHALF = CW'(OVS / 2 - 1);

  rx_state_t     st;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sh;
  logic          s1, s2;

  assign push = (st == RX_STOP) && tick && (cnt == CLAST) && s2 && !clr;
  assign data = sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st   <= RX_IDLE;
      cnt  <= '0;
      bitn <= '0;
      sh   <= '0;
    end else begin
      case (st)
        RX_IDLE: if (en && tick && !s2) begin
          st  <= RX_START;
          cnt <= '0;
        end
        RX_START: if (tick) begin
          if (cnt == CHALF) begin
            st   <= s2 ? RX_IDLE : RX_DATA;
            cnt  <= '0;
            bitn <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DATA: if (tick) begin
          if (cnt == CLAST) begin
            cnt <= '0;
            sh  <= {s2, sh[7:1]};
            if (bitn == 3'd7) st <= RX_STOP;
            else              bitn <= bitn + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_STOP: if (tick) begin
          if (cnt == CLAST) begin
            cnt <= '0;
            st  <= s2 ? RX_IDLE : RX_HOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_HOLD: if (s2) st <= RX_IDLE;
        default: st <= RX_IDLE;
      endcase
    end
  end

  assert_hold_after_bad_stop_R10: assert property (@(posedge clk) disable iff (rst || clr)
    (st == RX_STOP && tick && cnt == CLAST && !s2) |=> st == RX_HOLD);
endmodule

// File: rtl/ser_port_ctrl.sv
module ser_port_ctrl
  import ser_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 16,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              txd,
  input  logic              rxd
);
  logic              tx_en, rx_en;
  logic [MODE_W-1:0] mode_q;
  logic              sel_ctrl, sel_mode, sel_stat, sel_data;
  logic              tx_flush, rx_flush;
  logic              txq_full, txq_empty, txq_pop;
  logic [7:0]        txq_dout;
  logic              rxq_full, rxq_empty, rxq_pop, rx_push;
  logic [7:0]        rxq_dout, rx_byte;
  logic              tx_busy, tx_active;
  logic [31:0]       stat_word, rd_mux;

  assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
  assign sel_mode = (bus_addr == ADDR_W'(OFS_MODE));
  assign sel_stat = (bus_addr == ADDR_W'(OFS_STAT));
  assign sel_data = (bus_addr == ADDR_W'(OFS_DATA));

  assign tx_flush = bus_wr && sel_ctrl && bus_wdata[CB_TX_CLR];
  assign rx_flush = bus_wr && sel_ctrl && bus_wdata[CB_RX_CLR];

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en  <= 1'b0;
      rx_en  <= 1'b0;
      mode_q <= '0;
    end else begin
      if (bus_wr && sel_ctrl) begin
        tx_en <= bus_wdata[CB_TX_EN];
        rx_en <= bus_wdata[CB_RX_EN];
      end
      if (bus_wr && sel_mode) mode_q <= bus_wdata[MODE_W-1:0];
    end
  end

  ser_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .clr(tx_flush),
    .push(bus_wr && sel_data), .pop(txq_pop),
    .din(bus_wdata[7:0]), .dout(txq_dout),
    .full(txq_full), .empty(txq_empty)
  );

  ser_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .clr(tx_flush), .tick(sample_tick), .en(tx_en),
    .q_empty(txq_empty), .q_data(txq_dout), .q_pop(txq_pop),
    .txd(txd), .busy(tx_busy)
  );

  assign rxq_pop = bus_rd && sel_data && !rxq_empty;

  ser_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .clr(rx_flush),
    .push(rx_push), .pop(rxq_pop),
    .din(rx_byte), .dout(rxq_dout),
    .full(rxq_full), .empty(rxq_empty)
  );

  ser_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst(rst), .clr(rx_flush), .tick(sample_tick), .en(rx_en),
    .rxd(rxd), .push(rx_push), .data(rx_byte)
  );

  assign tx_active = tx_busy || !txq_empty;

  always_comb begin
    stat_word = '0;
    stat_word[SB_RX_EMPTY] = rxq_empty;
    stat_word[SB_TX_FULL]  = txq_full;
    stat_word[SB_TX_ACT]   = tx_active;
  end

  always_comb begin
    rd_mux = '0;
    if (sel_ctrl) begin
      rd_mux[CB_TX_EN] = tx_en;
      rd_mux[CB_RX_EN] = rx_en;
    end else if (sel_mode) begin
      rd_mux[MODE_W-1:0] = mode_q;
    end else if (sel_stat) begin
      rd_mux = stat_word;
    end else if (sel_data && !rxq_empty) begin
      rd_mux[7:0] = rxq_dout;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assert_empty_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel_data && rxq_empty) |=> bus_rdata == 32'd0);
  assert_busy_means_active_R8: assert property (@(posedge clk) disable iff (rst)
    tx_busy |-> stat_word[SB_TX_ACT]);
endmodule

// File: tb/ser_port_ctrl_tb.sv
module ser_port_ctrl_tb;
  localparam int OVS  = 16;
  localparam int TDIV = 4;
  localparam int BITC = OVS * TDIV;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        txd;
  logic        lb = 1'b0;
  logic        drv = 1'b1;
  logic        rxd;
  int          total = 0, bad = 0;
  int          tcnt = 0;
  int          cyc = 0;
  logic [7:0]  sent [17];

  assign rxd = lb ? txd : drv;

  always #10 clk = ~clk;

  always_ff @(posedge clk) begin
    tcnt <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
    tick <= (tcnt == TDIV - 1);
    cyc  <= cyc + 1;
  end

  ser_port_ctrl #(.ADDR_W(8), .DEPTH(16), .OVS(OVS)) u_dut (
    .clk(clk), .rst(rst), .sample_tick(tick), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rd(rd), .bus_rdata(rdata), .txd(txd), .rxd(rxd)
  );

  function automatic logic [31:0] stat_exp(input bit rx_empty, input bit tx_full, input bit act);
    logic [31:0] v = '0;
    v[1]  = rx_empty;
    v[4]  = tx_full;
    v[11] = act;
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic grab(output logic [7:0] b);
    while (txd !== 1'b0) @(negedge clk);
    repeat (BITC + BITC / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      b[i] = txd;
      repeat (BITC) @(negedge clk);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic stopb);
    @(negedge clk);
    drv = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      drv = b[i];
      repeat (BITC) @(negedge clk);
    end
    drv = stopb;
    repeat (BITC) @(negedge clk);
    drv = 1'b1;
    repeat (4 * BITC) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [7:0]  b;
    int lows;
    void'($urandom(32'd7719));
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    bus_read(8'h00, r); chk("R1 ctrl", r, 32'h0);
    bus_read(8'h04, r); chk("R1 mode", r, 32'h0);
    bus_read(8'h2C, r); chk("R1 status", r, stat_exp(1, 0, 0));
    chk("R1 txd", {31'b0, txd}, 32'h1);

    // R2 R11: enables with both flushes in one write
    bus_write(8'h00, 32'h17);
    bus_read(8'h00, r); chk("R2 R11 ctrl readback", r, 32'h14);
    bus_read(8'h2C, r); chk("R11 status after flush", r, stat_exp(1, 0, 0));

    // R3 mode word
    bus_write(8'h04, 32'h20);
    bus_read(8'h04, r); chk("R3 mode 0x20", r, 32'h20);
    bus_write(8'h04, 32'hFFFF_FFFF);
    bus_read(8'h04, r); chk("R3 mode mask", r, 32'h7FF);
    bus_write(8'h04, 32'h20);

    // R12 unused offsets
    bus_write(8'h08, 32'hFFFF_FFFF);
    bus_write(8'h18, 32'hFFFF_FFFF);
    bus_read(8'h08, r); chk("R12 read 0x08", r, 32'h0);
    bus_read(8'h18, r); chk("R12 read 0x18", r, 32'h0);
    bus_read(8'h00, r); chk("R12 ctrl untouched", r, 32'h14);
    bus_read(8'h04, r); chk("R12 mode untouched", r, 32'h20);
    bus_read(8'h2C, r); chk("R12 status untouched", r, stat_exp(1, 0, 0));

    // R6 R7: fill the transmit queue with the transmitter disabled
    lb = 1'b1;
    bus_write(8'h00, 32'h04);
    sent[0] = 8'h00;
    sent[1] = 8'hFF;
    for (int i = 2; i < 16; i++) sent[i] = 8'($urandom());
    sent[16] = 8'hEE;
    for (int i = 0; i < 17; i++) bus_write(8'h30, {24'h0, sent[i]});
    bus_read(8'h2C, r); chk("R4 R6 full and active", r, stat_exp(1, 1, 1));
    lows = 0;
    for (int i = 0; i < 40; i++) begin
      repeat (10) @(negedge clk);
      if (txd !== 1'b1) lows++;
    end
    chk("R7 line idle while disabled", lows, 0);

    // R5 frames on the line, R8 active clears when drained
    bus_write(8'h00, 32'h14);
    for (int i = 0; i < 16; i++) begin
      grab(b);
      chk("R5 R6 transmitted byte", {24'h0, b}, {24'h0, sent[i]});
    end
    repeat (3 * BITC) @(negedge clk);
    bus_read(8'h2C, r); chk("R8 idle after drain", r, stat_exp(0, 0, 0));

    // R9 receive path (loopback)
    for (int i = 0; i < 16; i++) begin
      bus_read(8'h30, r);
      chk("R9 received byte", r, {24'h0, sent[i]});
    end
    bus_read(8'h30, r); chk("R9 R6 empty read zero", r, 32'h0);
    bus_read(8'h2C, r); chk("R9 empty after drain", r, stat_exp(1, 0, 0));

    // R11 transmit flush drops queued bytes
    bus_write(8'h00, 32'h04);
    for (int i = 0; i < 3; i++) bus_write(8'h30, 32'hA0 + i);
    bus_read(8'h2C, r); chk("R8 queued active", r, stat_exp(1, 0, 1));
    bus_write(8'h00, 32'h06);
    bus_read(8'h2C, r); chk("R11 tx flush status", r, stat_exp(1, 0, 0));
    bus_write(8'h00, 32'h14);
    repeat (12 * BITC) @(negedge clk);
    bus_read(8'h2C, r); chk("R11 nothing sent after flush", r, stat_exp(1, 0, 0));

    // R11 receive flush
    bus_write(8'h30, 32'h5A);
    repeat (12 * BITC) @(negedge clk);
    bus_read(8'h2C, r); chk("R9 byte arrived", r, stat_exp(0, 0, 0));
    bus_write(8'h00, 32'h15);
    bus_read(8'h2C, r); chk("R11 rx flush status", r, stat_exp(1, 0, 0));
    bus_read(8'h30, r); chk("R11 rx flush data", r, 32'h0);

    // R10 bad stop bit, then a good frame from the bench driver
    lb = 1'b0;
    send(8'hA5, 1'b0);
    bus_read(8'h2C, r); chk("R10 bad frame dropped", r, stat_exp(1, 0, 0));
    send(8'h3C, 1'b1);
    bus_read(8'h30, r); chk("R9 R10 good frame", r, 32'h3C);

    // R13 receiver disabled
    bus_write(8'h00, 32'h10);
    send(8'h81, 1'b1);
    bus_read(8'h2C, r); chk("R13 ignored when disabled", r, stat_exp(1, 0, 0));
    bus_write(8'h00, 32'h14);

    // R11 flush in the middle of a frame
    bus_write(8'h30, 32'h00);
    repeat (3 * BITC) @(negedge clk);
    chk("R5 mid-frame line low", {31'b0, txd}, 32'h0);
    bus_write(8'h00, 32'h16);
    chk("R11 line high after abort", {31'b0, txd}, 32'h1);
    bus_read(8'h2C, r); chk("R11 inactive after abort", r, stat_exp(1, 0, 0));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule